// File: doc/BRIEF.md
# Two-Wire Serial Target with Register Interface

This block lets a small processor answer as an addressed target on a two-wire serial bus (SCL clock, SDA data, both open-drain with external pull-ups). Software sets the target's 7-bit address and a small control word through a four-register port. The block samples both bus lines with the system clock and detects START and STOP conditions. After each START it shifts in the address byte. When the address matches, it moves a byte at a time in either direction, with the acknowledge bit on the ninth clock.

Software sees four registers on a 2-bit register address. Offset 0 holds the target address, offset 1 the control bits, offset 2 the status flags, and offset 3 the data (reads give the last received byte, writes set the next byte to send). A one-cycle interrupt pulse marks an address match and the end of every data byte. Before a receive, software does a dummy read of the data register. In the interrupt it checks the direction flag and picks transmit or receive mode. The block never stretches the clock and never acts as bus master.

Top module: `iic_target_ctl`

## Requirements
- R1: After reset all readable registers return 0x00, and both line enables `sda_oe` and `scl_oe` are 0.
- R2: The target address sits in bits 7:1 of offset 0. Bit 0 is not stored, reads as 0 and plays no part in matching. The first 8 bits after a START are taken MSB first. When their upper 7 bits equal the target address, the block pulls SDA low on the ninth clock, sets the addressed flag (status bit 1) and pulses `irq`.
- R3: On an address mismatch the block leaves SDA released on the ninth clock and clears the addressed flag. Until the next START it ignores the bus: no data is captured, no `irq` is raised and SDA is never pulled.
- R4: Any write to offset 1 clears the addressed flag.
- R5: The eighth bit of a matched address byte is latched into status bit 3 (1 means the master reads and the target sends).
- R6: In receive mode (control bit 1 = 0) each data byte is shifted in MSB first and becomes readable at offset 3. Status bit 0 (byte done) reads 0 while a data byte is being shifted and goes to 1 when its eighth bit is taken, at the same moment `irq` pulses.
- R7: In receive mode the target drives control bit 2 onto SDA on the ninth clock of each data byte: 0 pulls SDA low (ACK), 1 leaves it released (NACK).
- R8: In transmit mode (control bit 1 = 1) the byte written to offset 3 is sent MSB first, starting on the SCL fall that ends the address acknowledge. After each ACK from the master, the current content of offset 3 is sent next. Each byte sent raises byte done and pulses `irq`.
- R9: In transmit mode the SDA level the master gives on the ninth clock is captured into status bit 4 (0 ACK, 1 NACK). After a NACK the target releases SDA and drives nothing until the next START.
- R10: Status bit 2 (bus busy) sets on a START (SDA falling while SCL is high) and clears on a STOP (SDA rising while SCL is high).
- R11: Control bit 0 enables the block. While it is 0, SDA is never pulled, `irq` stays low, and the busy and addressed flags do not set.
- R12: The block never pulls SCL low (`scl_oe` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register offset: 0 address, 1 control, 2 status, 3 data |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for `reg_addr`, valid one cycle later |
| scl_i | input | 1 | Level on the SCL line |
| sda_i | input | 1 | Level on the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 (held at 0) |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
A phase register that slips by one SCL edge shows at the ports within that same bit time. The acknowledge lands on the wrong clock and the master sees a missing or spurious ACK, or a received byte reads back rotated by one bit. A shift register or comparison fault shows in the ninth-clock level of the very next address byte and in the byte read from offset 3 right after the transfer. A flag that fails to set or clear shows in the next status read, and a stuck phase shows as SDA held low past a NACK, which the master sees on its next sampled bit.

// File: rtl/iic_pkg.sv
package iic_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = DATA_W - 1;
  localparam int REG_AW = 2;
  localparam int CTL_W  = 3;

  localparam logic [REG_AW-1:0] REG_OWN  = 2'd0;
  localparam logic [REG_AW-1:0] REG_CTL  = 2'd1;
  localparam logic [REG_AW-1:0] REG_STAT = 2'd2;
  localparam logic [REG_AW-1:0] REG_DATA = 2'd3;

  localparam int CTL_EN  = 0;
  localparam int CTL_TX  = 1;
  localparam int CTL_NAK = 2;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_AACKW, PH_AACK,
    PH_RX, PH_RACKW, PH_RACK,
    PH_TX, PH_TACKW, PH_TACK, PH_TNEXT,
    PH_SKIP
  } phase_t;

  typedef struct packed {
    logic rx_nack;
    logic rw;
    logic busy;
    logic hit;
    logic done;
  } stat_t;
endpackage

// File: rtl/iic_pin_sync.sv
module iic_pin_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] clean
);
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= '1;
      else     ff <= {ff[STAGES-2:0], raw[i]};
    end
    assign clean[i] = ff[STAGES-1];
  end
endmodule

// File: rtl/iic_byte_engine.sv
module iic_byte_engine
  import iic_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              en,
  input  logic              tx_mode,
  input  logic              tx_nack,
  input  logic              ctl_wr,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic [DATA_W-1:0] tx_byte,
  output logic [DATA_W-1:0] rx_byte,
  output logic              sda_pull,
  output logic              irq,
  output logic              start_evt,
  output logic              stop_evt,
  output stat_t             stat
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  phase_t            ph;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sh;
  logic              scl_q, sda_q;
  logic              scl_rise, scl_fall;
  logic [DATA_W-1:0] shift_in;

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = en & scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = en & scl_s & scl_q & ~sda_q & sda_s;
  assign shift_in  = {sh[DATA_W-2:0], sda_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      sh       <= '0;
      rx_byte  <= '0;
      sda_pull <= 1'b0;
      irq      <= 1'b0;
      stat     <= '0;
    end else begin
      irq <= 1'b0;
      if (!en) begin
        ph        <= PH_IDLE;
        sda_pull  <= 1'b0;
        stat.busy <= 1'b0;
      end else if (start_evt) begin
        ph        <= PH_ADDR;
        cnt       <= '0;
        sda_pull  <= 1'b0;
        stat.busy <= 1'b1;
        stat.done <= 1'b0;
      end else if (stop_evt) begin
        ph        <= PH_IDLE;
        sda_pull  <= 1'b0;
        stat.busy <= 1'b0;
      end else begin
        unique case (ph)
          PH_ADDR: if (scl_rise) begin
            sh  <= shift_in;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) begin
              if (sh[ADDR_W-1:0] == own_addr) begin
                stat.hit <= 1'b1;
                stat.rw  <= sda_s;
                irq      <= 1'b1;
                ph       <= PH_AACKW;
              end else begin
                stat.hit <= 1'b0;
                ph       <= PH_SKIP;
              end
            end
          end
          PH_AACKW: if (scl_fall) begin
            sda_pull <= 1'b1;
            ph       <= PH_AACK;
          end
          PH_AACK: if (scl_fall) begin
            cnt <= '0;
            if (tx_mode) begin
              sh       <= tx_byte;
              sda_pull <= ~tx_byte[DATA_W-1];
              ph       <= PH_TX;
            end else begin
              sda_pull <= 1'b0;
              ph       <= PH_RX;
            end
          end
          PH_RX: if (scl_rise) begin
            sh  <= shift_in;
            cnt <= cnt + 1'b1;
            if (cnt == '0) stat.done <= 1'b0;
            if (cnt == LAST) begin
              rx_byte   <= shift_in;
              stat.done <= 1'b1;
              irq       <= 1'b1;
              ph        <= PH_RACKW;
            end
          end
          PH_RACKW: if (scl_fall) begin
            sda_pull <= ~tx_nack;
            ph       <= PH_RACK;
          end
          PH_RACK: if (scl_fall) begin
            sda_pull <= 1'b0;
            cnt      <= '0;
            ph       <= PH_RX;
          end
          PH_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (cnt == '0) stat.done <= 1'b0;
              if (cnt == LAST) begin
                stat.done <= 1'b1;
                irq       <= 1'b1;
                ph        <= PH_TACKW;
              end
            end else if (scl_fall) begin
              sh       <= {sh[DATA_W-2:0], sh[DATA_W-1]};
              sda_pull <= ~sh[DATA_W-2];
            end
          end
          PH_TACKW: if (scl_fall) begin
            sda_pull <= 1'b0;
            ph       <= PH_TACK;
          end
          PH_TACK: if (scl_rise) begin
            stat.rx_nack <= sda_s;
            ph           <= sda_s ? PH_SKIP : PH_TNEXT;
          end
          PH_TNEXT: if (scl_fall) begin
            sh       <= tx_byte;
            sda_pull <= ~tx_byte[DATA_W-1];
            cnt      <= '0;
            ph       <= PH_TX;
          end
          default: ;
        endcase
      end
      if (ctl_wr) stat.hit <= 1'b0;
    end
  end
endmodule

// File: rtl/iic_target_ctl.sv
module iic_target_ctl
  import iic_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              irq
);
  logic [ADDR_W-1:0] own_q;
  logic [CTL_W-1:0]  ctl_q;
  logic [DATA_W-1:0] tx_q;
  logic [DATA_W-1:0] rx_w;
  logic [1:0]        lines_s;
  logic              ctl_wr, en_w, start_w, stop_w;
  stat_t             stat_w;

  assign ctl_wr = reg_wr && (reg_addr == REG_CTL);
  assign en_w   = ctl_q[CTL_EN];
  assign scl_oe = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q <= '0;
      ctl_q <= '0;
      tx_q  <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        REG_OWN:  own_q <= reg_wdata[DATA_W-1:1];
        REG_CTL:  ctl_q <= reg_wdata[CTL_W-1:0];
        REG_DATA: tx_q  <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else begin
      case (reg_addr)
        REG_OWN:  reg_rdata <= {own_q, 1'b0};
        REG_CTL:  reg_rdata <= DATA_W'(ctl_q);
        REG_STAT: reg_rdata <= DATA_W'(stat_w);
        default:  reg_rdata <= rx_w;
      endcase
    end
  end

  iic_pin_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .raw   ({scl_i, sda_i}),
    .clean (lines_s)
  );

  iic_byte_engine u_eng (
    .clk       (clk),
    .rst       (rst),
    .scl_s     (lines_s[1]),
    .sda_s     (lines_s[0]),
    .en        (en_w),
    .tx_mode   (ctl_q[CTL_TX]),
    .tx_nack   (ctl_q[CTL_NAK]),
    .ctl_wr    (ctl_wr),
    .own_addr  (own_q),
    .tx_byte   (tx_q),
    .rx_byte   (rx_w),
    .sda_pull  (sda_oe),
    .irq       (irq),
    .start_evt (start_w),
    .stop_evt  (stop_w),
    .stat      (stat_w)
  );
endmodule

// File: rtl/iic_target_ctl_chk.sv
module iic_target_ctl_chk
  import iic_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              irq,
  input logic              sda_oe,
  input logic              en,
  input logic              start_evt,
  input logic              stop_evt,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input stat_t             stat
);
  // R10: busy follows START and STOP
  a_r10_busy_on_start: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> stat.busy);
  a_r10_busy_off_stop: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> !stat.busy);
  // R4: control write wipes the addressed flag
  a_r4_ctl_clears_hit: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == REG_CTL) |=> !stat.hit);
  // R11: disabled block stays silent
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (!sda_oe && !irq));
  // R6: interrupt is a single-cycle pulse
  a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R6: a finished byte only ever happens inside a busy bus period
  a_r6_done_in_busy: assert property (@(posedge clk) disable iff (rst)
    $rose(stat.done) |-> stat.busy);
endmodule

bind iic_target_ctl iic_target_ctl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .sda_oe    (sda_oe),
  .en        (en_w),
  .start_evt (start_w),
  .stop_evt  (stop_w),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .stat      (stat_w)
);

// File: tb/iic_target_ctl_tb_top.sv
module iic_target_ctl_tb_top;
  import iic_pkg::*;

  localparam int CLK_P = 10;
  localparam int Q     = 12;
  localparam int WDOG  = 150000;
  localparam logic [6:0] OWN = 7'h2D;

  // {address, data, expect_ack}
  localparam logic [15:0] VEC [6] = '{
    {7'h2D, 8'hA5, 1'b1},
    {7'h2D, 8'h00, 1'b1},
    {7'h2C, 8'h3C, 1'b0},
    {7'h2D, 8'hFF, 1'b1},
    {7'h6D, 8'h81, 1'b0},
    {7'h2D, 8'h5E, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic [1:0] reg_addr  = '0;
  logic       reg_wr    = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       irq, sda_oe, scl_oe;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  wire        scl_line = m_scl & ~scl_oe;
  wire        sda_line = m_sda & ~sda_oe;

  iic_target_ctl dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  int total = 0, bad = 0, irq_n = 0, scl_hits = 0;
  bit finished = 1'b0;

  always @(posedge clk) if (!rst && irq) irq_n++;
  always @(negedge clk) if (scl_oe) scl_hits++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic cpu_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic cpu_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic do_start();
    m_sda = 1'b1; m_scl = 1'b1; qw();
    m_sda = 1'b0; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic do_stop();
    m_sda = 1'b0; qw();
    m_scl = 1'b1; qw();
    m_sda = 1'b1; qw();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; qw();
    m_scl = 1'b1; qw(); qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic recv_bit(output logic b);
    m_sda = 1'b1; qw();
    m_scl = 1'b1; qw();
    b = sda_line; qw();
    m_scl = 1'b0; qw();
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(b);
    ack = ~b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic nack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, last_rx, b1, b2;
    logic ack, bit_v;
    int irq0;

    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    for (int a = 0; a < 4; a++) begin
      cpu_rd(a[1:0], rd);
      chk("R1 reg after reset", rd, 8'h00);
    end
    chk("R1 sda_oe after reset", sda_oe, 1'b0);
    chk("R1 scl_oe after reset", scl_oe, 1'b0);

    // R2: bit 0 of the address register is not kept
    cpu_wr(REG_OWN, {OWN, 1'b1});
    cpu_rd(REG_OWN, rd);
    chk("R2 own address readback", rd, {OWN, 1'b0});
    cpu_wr(REG_CTL, 8'h01);

    // R10: busy between START and STOP
    do_start();
    cpu_rd(REG_STAT, rd);
    chk("R10 busy after start", rd[2], 1'b1);
    do_stop();
    cpu_rd(REG_STAT, rd);
    chk("R10 idle after stop", rd[2], 1'b0);

    // vector walk: receive transfers, R2 R3 R5 R6 R7
    last_rx = 8'h00;
    foreach (VEC[k]) begin
      cpu_rd(REG_DATA, rd);
      irq0 = irq_n;
      do_start();
      send_byte({VEC[k][15:9], 1'b0}, ack);
      chk(VEC[k][0] ? "R2 address ack" : "R3 address no ack", ack, VEC[k][0]);
      cpu_rd(REG_STAT, rd);
      chk(VEC[k][0] ? "R2 addressed flag" : "R3 addressed flag", rd[1], VEC[k][0]);
      if (VEC[k][0]) chk("R5 write direction bit", rd[3], 1'b0);
      send_byte(VEC[k][8:1], ack);
      chk(VEC[k][0] ? "R7 data ack" : "R3 data ignored", ack, VEC[k][0]);
      if (VEC[k][0]) last_rx = VEC[k][8:1];
      cpu_rd(REG_DATA, rd);
      chk("R6 received byte", rd, last_rx);
      cpu_rd(REG_STAT, rd);
      chk("R6 byte done flag", rd[0], VEC[k][0]);
      chk(VEC[k][0] ? "R6 irq count" : "R3 no irq", irq_n - irq0, VEC[k][0] ? 2 : 0);
      do_stop();
      cpu_rd(REG_STAT, rd);
      chk("R10 busy clear", rd[2], 1'b0);
    end

    // R7: NACK from control bit 2, R4 clear by control write
    cpu_wr(REG_CTL, 8'h05);
    do_start();
    send_byte({OWN, 1'b0}, ack);
    chk("R2 address ack with nack bit set", ack, 1'b1);
    send_byte(8'h71, ack);
    chk("R7 nack driven", ack, 1'b0);
    do_stop();
    cpu_rd(REG_DATA, rd);
    chk("R6 byte captured under nack", rd, 8'h71);
    cpu_rd(REG_STAT, rd);
    chk("R4 addressed before write", rd[1], 1'b1);
    cpu_wr(REG_CTL, 8'h01);
    cpu_rd(REG_STAT, rd);
    chk("R4 addressed cleared", rd[1], 1'b0);

    // R6: done reads 0 mid-byte
    do_start();
    send_byte({OWN, 1'b0}, ack);
    send_byte(8'h11, ack);
    cpu_rd(REG_STAT, rd);
    chk("R6 done after first byte", rd[0], 1'b1);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    cpu_rd(REG_STAT, rd);
    chk("R6 done low while shifting", rd[0], 1'b0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    recv_bit(bit_v);
    chk("R7 ack second byte", bit_v, 1'b0);
    cpu_rd(REG_STAT, rd);
    chk("R6 done at byte end", rd[0], 1'b1);
    cpu_rd(REG_DATA, rd);
    chk("R6 second byte", rd, 8'h22);
    do_stop();

    // R8 R9 R5: transmit
    cpu_wr(REG_CTL, 8'h03);
    cpu_wr(REG_DATA, 8'hC3);
    irq0 = irq_n;
    do_start();
    send_byte({OWN, 1'b1}, ack);
    chk("R2 read address ack", ack, 1'b1);
    cpu_rd(REG_STAT, rd);
    chk("R5 read direction bit", rd[3], 1'b1);
    fork
      recv_byte(b1, 1'b0);
      begin
        repeat (60) @(negedge clk);
        cpu_wr(REG_DATA, 8'h96);
      end
    join
    chk("R8 first byte sent", b1, 8'hC3);
    cpu_rd(REG_STAT, rd);
    chk("R9 ack captured", rd[4], 1'b0);
    recv_byte(b2, 1'b1);
    chk("R8 second byte sent", b2, 8'h96);
    cpu_rd(REG_STAT, rd);
    chk("R9 nack captured", rd[4], 1'b1);
    chk("R8 irq per byte", irq_n - irq0, 3);
    recv_bit(bit_v);
    chk("R9 sda released after nack", bit_v, 1'b1);
    chk("R9 no drive after nack", sda_oe, 1'b0);
    do_stop();

    // R11: disabled
    cpu_wr(REG_CTL, 8'h00);
    irq0 = irq_n;
    do_start();
    cpu_rd(REG_STAT, rd);
    chk("R11 busy stays clear", rd[2], 1'b0);
    send_byte({OWN, 1'b0}, ack);
    chk("R11 no ack when off", ack, 1'b0);
    cpu_rd(REG_STAT, rd);
    chk("R11 addressed stays clear", rd[1], 1'b0);
    chk("R11 no irq when off", irq_n - irq0, 0);
    do_stop();

    chk("R12 scl never pulled", scl_hits, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule